// File: doc/BRIEF.md
# Card Controller Status and Interrupt Unit

This unit holds the status word of a memory-card host controller and turns it into two interrupt lines. The low part of the word is a set of sticky event flags. The command and data units raise these flags with one-cycle set pulses. A flag stays set until software clears it. The upper part of the word carries live flags: command-active and ten FIFO condition flags. These are passed through from the data engine exactly as they arrive, with no storage.

Two mask registers each select a subset of the status word. Each interrupt output is a registered OR of the status bits its own mask enables, so the two lines work independently. A write-one-to-clear register acts on the event flags only. A read-only window at the top of the address map returns a fixed eight-byte identification sequence.

The host reaches the unit through a plain 32-bit register port:
- an address,
- a write strobe with write data,
- a read-data bus that always shows the register at the current address.

Reads have no side effects, so the port needs no read strobe. No data stream passes through this unit, so it has no valid/ready interface.

Top module: `mmc_status_irq`

## Requirements
- R1: After reset, the status word's sticky bits, both mask registers and both interrupt outputs are all zero.
- R2: A set pulse on an event bit (0 to 8, or 10) makes that status bit read 1 from the cycle after the pulse. The bit then holds until it is cleared.
- R3: Status bit 9 is not an event flag. A set pulse on it has no effect, and the bit always reads 0.
- R4: A write to offset 0x38 clears every status bit that is set both in the written value and in 0x7FF. All other sticky bits are unchanged.
- R5: Bits 11 and above cannot be cleared by a write to 0x38.
- R6: When a set pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A read of offset 0x34 returns the status word, laid out as follows:
  - bits 10:0 are the sticky flags;
  - bit 11 is `cmd_active`;
  - bits 21:12 are `fifo_flags[9:0]`;
  - bits 31:22 are zero.
- R8: Mask 0 is written and read at offset 0x3C, and mask 1 at offset 0x40, with all 32 bits kept.
- R9: `irq[i]` is high exactly when (status AND mask i) was nonzero in the previous cycle, for i = 0 and 1. The two lines are independent.
- R10: A read at any offset from 0xFE0 to 0xFFF returns a byte selected by offset bits [4:2]. Index 0 to 7 gives 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: A read of any other offset returns zero. A write to any other offset changes no status or mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_set | input | 11 | One-cycle set pulses for the sticky flags |
| cmd_active | input | 1 | Live command-active flag |
| fifo_flags | input | 10 | Live FIFO condition flags |
| irq | output | 2 | Level interrupt outputs, one per mask |

## Verification
The event set path and the software clear path can both act on the same sticky bit in the same cycle. The bench provokes this by raising the set pulse in the same cycle as the clear write, with both aimed at the same bit. It judges the result by reading the status word afterwards: the bit must still be set, while a neighbouring bit covered by the same clear must be gone. A clear can also land while an interrupt is pending. There the bench checks that the interrupt line falls exactly one cycle after the status bit drops.

// File: rtl/mmc_stat_pkg.sv
package mmc_stat_pkg;

  // Register offsets (byte addresses)
  localparam logic [11:0] OFS_STATUS = 12'h034;
  localparam logic [11:0] OFS_CLEAR  = 12'h038;
  localparam logic [11:0] OFS_MASK0  = 12'h03C;
  localparam logic [11:0] OFS_MASK1  = 12'h040;

  // Only these status bits can be cleared by software
  localparam logic [31:0] CLEARABLE = 32'h0000_07FF;

  // Identification byte for a given window index
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h81;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/msi_sticky_bank.sv
module msi_sticky_bank #(
  parameter int             EVT_W    = 11,
  parameter logic [EVT_W-1:0] EVT_IMPL = 11'h5FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_set,
  input  logic             clr_stb,
  input  logic [EVT_W-1:0] clr_val,
  output logic [EVT_W-1:0] sticky
);
  logic [EVT_W-1:0] clr_eff;
  logic [EVT_W-1:0] sticky_d;

  always_comb begin
    clr_eff  = clr_stb ? clr_val : '0;
    // set wins over clear in the same cycle
    sticky_d = (sticky & ~clr_eff) | (evt_set & EVT_IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= sticky_d;
  end
endmodule

// File: rtl/msi_irq_unit.sv
module msi_irq_unit #(
  parameter int DATA_W  = 32,
  parameter int NUM_IRQ = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         status,
  input  logic [NUM_IRQ-1:0]        mask_we,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_IRQ*DATA_W-1:0] masks,
  output logic [NUM_IRQ-1:0]        irq
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        irq[g] <= 1'b0;
      end else begin
        if (mask_we[g]) mask_q <= wdata;
        irq[g] <= |(status & mask_q);
      end
    end

    assign masks[g*DATA_W +: DATA_W] = mask_q;
  end
endmodule

// File: rtl/msi_id_rom.sv
module msi_id_rom #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        idx,
  output logic [DATA_W-1:0] value
);
  import mmc_stat_pkg::*;
  always_comb value = DATA_W'(id_byte(idx));
endmodule

// File: rtl/mmc_status_irq.sv
module mmc_status_irq #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int EVT_W   = 11,
  parameter int FIFO_W  = 10,
  parameter int NUM_IRQ = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [EVT_W-1:0]   evt_set,
  input  logic               cmd_active,
  input  logic [FIFO_W-1:0]  fifo_flags,
  output logic [NUM_IRQ-1:0] irq
);
  import mmc_stat_pkg::*;

  localparam int STAT_W = EVT_W + 1 + FIFO_W;
  localparam int PAD_W  = DATA_W - STAT_W;
  localparam int WIN_W  = ADDR_W - 5;

  logic [EVT_W-1:0]          sticky_q;
  logic [DATA_W-1:0]         status_word;
  logic [NUM_IRQ*DATA_W-1:0] masks;
  logic [NUM_IRQ-1:0]        mask_we;
  logic [DATA_W-1:0]         id_val;
  logic                      clr_stb;
  logic                      in_id_win;

  assign clr_stb     = reg_we && (reg_addr == OFS_CLEAR[ADDR_W-1:0]);
  assign mask_we[0]  = reg_we && (reg_addr == OFS_MASK0[ADDR_W-1:0]);
  assign mask_we[1]  = reg_we && (reg_addr == OFS_MASK1[ADDR_W-1:0]);
  assign status_word = {{PAD_W{1'b0}}, fifo_flags, cmd_active, sticky_q};
  assign in_id_win   = &reg_addr[ADDR_W-1:5];

  msi_sticky_bank #(.EVT_W(EVT_W)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_set (evt_set),
    .clr_stb (clr_stb),
    .clr_val (reg_wdata[EVT_W-1:0] & CLEARABLE[EVT_W-1:0]),
    .sticky  (sticky_q)
  );

  msi_irq_unit #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status_word),
    .mask_we (mask_we),
    .wdata   (reg_wdata),
    .masks   (masks),
    .irq     (irq)
  );

  msi_id_rom #(.DATA_W(DATA_W)) u_id (
    .idx   (reg_addr[4:2]),
    .value (id_val)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_id_win) begin
      reg_rdata = id_val;
    end else begin
      case (reg_addr)
        OFS_STATUS[ADDR_W-1:0]: reg_rdata = status_word;
        OFS_MASK0[ADDR_W-1:0]:  reg_rdata = masks[0 +: DATA_W];
        OFS_MASK1[ADDR_W-1:0]:  reg_rdata = masks[DATA_W +: DATA_W];
        default:                reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmc_status_irq_chk.sv
module mmc_status_irq_chk #(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_stb,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [EVT_W-1:0]  evt_set,
  input logic [EVT_W-1:0]  sticky_q,
  input logic [DATA_W-1:0] status_word,
  input logic [DATA_W-1:0] mask0,
  input logic [DATA_W-1:0] mask1,
  input logic [1:0]        irq
);
  localparam logic [EVT_W-1:0] IMPL = 11'h5FF;

  // R2: a pulsed event bit is set in the next cycle
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_set & IMPL)) |=> ((sticky_q & $past(evt_set & IMPL)) == $past(evt_set & IMPL)));

  // R3: the reserved bit never gets set
  a_r3_bit9_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_q[9]);

  // R4: a clear removes its bits unless they are set again in that cycle
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((sticky_q & $past(reg_wdata[EVT_W-1:0] & ~evt_set)) == '0));

  // R6: a set pulse beats a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && (|(evt_set & IMPL))) |=> ((sticky_q & $past(evt_set & IMPL)) == $past(evt_set & IMPL)));

  // R2: with no set and no clear, the sticky bits hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_stb && evt_set == '0) |=> $stable(sticky_q));

  // R9: each line follows its masked status one cycle later
  a_r9_irq0: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq[0] == |($past(status_word) & $past(mask0))));
  a_r9_irq1: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq[1] == |($past(status_word) & $past(mask1))));
endmodule

bind mmc_status_irq mmc_status_irq_chk #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_stb     (clr_stb),
  .reg_wdata   (reg_wdata),
  .evt_set     (evt_set),
  .sticky_q    (sticky_q),
  .status_word (status_word),
  .mask0       (masks[0 +: DATA_W]),
  .mask1       (masks[DATA_W +: DATA_W]),
  .irq         (irq)
);

// File: tb/mmc_status_irq_tb.sv
module mmc_status_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] evt_set = '0;
  logic        cmd_active = 1'b0;
  logic [9:0]  fifo_flags = '0;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #10 clk = ~clk;   // 50 MHz

  mmc_status_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .cmd_active(cmd_active), .fifo_flags(fifo_flags), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h034, d); check("R1 status", d, 32'h0);
    rd(12'h03C, d); check("R1 mask0", d, 32'h0);
    rd(12'h040, d); check("R1 mask1", d, 32'h0);
    check("R1 irq", {30'h0, irq}, 32'h0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    pulse(11'h508);
    rd(12'h034, d); check("R2 set bits 3,8,10", d, 32'h508);
    pulse(11'h200);
    rd(12'h034, d); check("R3 bit9 pulse ignored", d, 32'h508);
    repeat (3) @(negedge clk);
    rd(12'h034, d); check("R2 bits held", d, 32'h508);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(12'h038, 32'h0000_0008);
    rd(12'h034, d); check("R4 partial clear", d, 32'h500);
    cmd_active = 1'b1; fifo_flags = 10'h3FF;
    wr(12'h038, 32'hFFFF_FFFF);
    rd(12'h034, d); check("R5 live bits survive clear", d, 32'h003F_F800);
    fifo_flags = 10'h155;
    #1;
    rd(12'h034, d); check("R7 live layout", d, 32'h0015_5800);
    cmd_active = 1'b0; fifo_flags = '0;
  endtask

  task automatic t_priority;
    logic [31:0] d;
    pulse(11'h006);
    @(negedge clk);
    reg_addr = 12'h038; reg_wdata = 32'h6; reg_we = 1'b1; evt_set = 11'h004;
    @(negedge clk);
    reg_we = 1'b0; evt_set = '0;
    rd(12'h034, d); check("R6 set beats clear", d, 32'h004);
    wr(12'h038, 32'h7FF);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(12'h03C, 32'h0000_0100);
    wr(12'h040, 32'hA5A5_0004);
    rd(12'h03C, d); check("R8 mask0 readback", d, 32'h0000_0100);
    rd(12'h040, d); check("R8 mask1 readback", d, 32'hA5A5_0004);
    pulse(11'h100);
    check("R9 irq not yet", {30'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq0 only", {30'h0, irq}, 32'h1);
    pulse(11'h004);
    @(negedge clk);
    check("R9 both lines", {30'h0, irq}, 32'h3);
    wr(12'h038, 32'h100);
    check("R9 irq0 lags clear", {30'h0, irq}, 32'h3);
    @(negedge clk);
    check("R9 irq0 dropped", {30'h0, irq}, 32'h2);
    wr(12'h038, 32'h004);
    @(negedge clk);
    check("R9 all low", {30'h0, irq}, 32'h0);
  endtask

  task automatic t_id;
    logic [31:0] d;
    logic [7:0]  exp [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), d);
      check("R10 id byte", d, {24'h0, exp[i]});
    end
    rd(12'hFFE, d); check("R10 id index 7 unaligned", d, 32'hB1);
  endtask

  task automatic t_undef;
    logic [31:0] d;
    pulse(11'h001);
    rd(12'h044, d); check("R11 undefined read", d, 32'h0);
    rd(12'h038, d); check("R11 clear reads zero", d, 32'h0);
    wr(12'h044, 32'hFFFF_FFFF);
    wr(12'h03D, 32'hFFFF_FFFF);
    rd(12'h034, d); check("R11 status untouched", d, 32'h1);
    rd(12'h03C, d); check("R11 mask0 untouched", d, 32'h100);
    rd(12'h040, d); check("R11 mask1 untouched", d, 32'hA5A5_0004);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_clear();
    t_priority();
    t_irq();
    t_id();
    t_undef();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule